// File: doc/BRIEF.md
# Load/Store Lane Alignment Unit

This block sits between an execution stage and a simple 32-bit memory port and carries out one load or store at a time. It forms the byte address from a base register value plus a signed 16-bit displacement. It checks that address against the access size. For a store it moves the source data onto the byte lanes that the address selects. For a load it picks the addressed byte or halfword out of the returned word and widens it to 32 bits with either zeros or copies of its sign bit.

A request is taken with a valid/ready pair. An access whose address suits its size is issued on the memory port in the next cycle. The port holds the request until memory accepts it. A load then waits for read data and returns the widened result one cycle after that data arrives. A misaligned access never reaches the memory port. It is reported instead by a one-cycle fault pulse, and the offending address is presented alongside the pulse. The memory bus is little-endian: address offset 0 sits on bits 7:0.

Top module: `mem_lane_unit`

## Requirements
- R1: The memory address equals base_i plus disp_i sign-extended to 32 bits, wrapping modulo 2^32.
- R2: A byte load with signed_i low returns the addressed lane (lane k = rdata bits 8k+7:8k, k = address bits 1:0), zero-extended to 32 bits.
- R3: A byte load with signed_i high returns the addressed lane with bit 7 copied into bits 31:8.
- R4: A halfword load returns rdata bits 15:0 when address bit 1 is 0 and bits 31:16 when it is 1, zero-extended when signed_i is low and sign-extended from bit 15 when it is high.
- R5: A word load (size 2'b10, or the spare code 2'b11, which behaves as a word) returns rdata unchanged, whatever signed_i is.
- R6: The size codes are 2'b00 byte, 2'b01 halfword, and 2'b10/2'b11 word. A byte access never faults. A halfword access faults on an odd address. A word access faults when address bits 1:0 are nonzero.
- R7: A faulting access raises no memory request and no load result. fault_o is high for exactly the cycle after acceptance, with fault_addr_o equal to the computed address.
- R8: Store strobes are 4'b0001, 4'b0011 or 4'b1111 for byte, halfword or word, shifted left by address bits 1:0. The enabled lanes carry the low byte, the low halfword or the full word of wdata_i, in ascending lane order.
- R9: An aligned request appears on the memory port in the cycle after acceptance. It keeps its address and strobes stable while mem_ready_i is low. req_ready_o stays low until the access completes.
- R10: A load result is flagged by ld_valid_o for one cycle, in the cycle after the one in which mem_rvalid_i is sampled high.
- R11: A store completes at its memory handshake, produces no ld_valid_o pulse, and ignores signed_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request present |
| req_ready_o | output | 1 | Unit can accept a request |
| write_i | input | 1 | 1 = store, 0 = load |
| size_i | input | 2 | Access size code |
| signed_i | input | 1 | Sign-extend load result |
| base_i | input | 32 | Base register value |
| disp_i | input | 16 | Signed displacement |
| wdata_i | input | 32 | Store source register |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory accepts request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Byte address |
| mem_be_o | output | 4 | Byte strobes |
| mem_wdata_o | output | 32 | Lane-aligned write data |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data word |
| fault_o | output | 1 | Alignment fault pulse |
| fault_addr_o | output | 32 | Faulting address |
| ld_valid_o | output | 1 | Load result valid |
| ld_data_o | output | 32 | Extended load result |

## Verification
An accepted request shows its effect one edge later. That effect is either a fault pulse with its address or a memory request with address, strobes and lane data. The bench samples both at the falling edge that follows the accepting rising edge, and again one cycle later to confirm that the fault has cleared. The memory request is re-sampled at every falling edge while the bench withholds mem_ready_i, to check that it is held. A load result is due exactly one edge after the edge that samples mem_rvalid_i. The bench checks that ld_valid_o stays low through every cycle it withholds read data, is high at that one falling edge, and is low again at the next.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / 8;
  localparam int unsigned LO_W   = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_REQ  = 2'b01,
    ST_RESP = 2'b10
  } lsu_state_e;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DISP_W = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [1:0]        size_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              misalign_o
);
  localparam int unsigned EXT_W = ADDR_W - DISP_W;

  assign ea_o = base_i + {{EXT_W{disp_i[DISP_W-1]}}, disp_i};

  always_comb begin
    unique case (size_e'(size_i))
      SZ_BYTE: misalign_o = 1'b0;
      SZ_HALF: misalign_o = ea_o[0];
      default: misalign_o = |ea_o[LO_W-1:0];
    endcase
  end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_pkg::*;
(
  input  logic [1:0]        size_i,
  input  logic [LO_W-1:0]   lo_i,
  input  logic [WORD_W-1:0] src_i,
  output logic [LANES-1:0]  be_o,
  output logic [WORD_W-1:0] data_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [LO_W-1:0] LANE_IDX = LO_W'(l);
    localparam int unsigned HALF_OFS = 8 * (l % 2);
    always_comb begin
      unique case (size_e'(size_i))
        SZ_BYTE: begin
          be_o[l]         = (lo_i == LANE_IDX);
          data_o[8*l +: 8] = src_i[7:0];
        end
        SZ_HALF: begin
          be_o[l]         = (lo_i[LO_W-1] == LANE_IDX[LO_W-1]);
          data_o[8*l +: 8] = src_i[HALF_OFS +: 8];
        end
        default: begin
          be_o[l]         = 1'b1;
          data_o[8*l +: 8] = src_i[8*l +: 8];
        end
      endcase
    end
  end
endmodule

// File: rtl/lsu_load_ext.sv
module lsu_load_ext
  import lsu_pkg::*;
(
  input  logic [1:0]        size_i,
  input  logic              signed_i,
  input  logic [LO_W-1:0]   lo_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic [WORD_W-1:0] result_o
);
  logic [7:0]  byte_sel;
  logic [15:0] half_sel;

  assign byte_sel = rdata_i[{lo_i, 3'b000} +: 8];
  assign half_sel = rdata_i[{lo_i[LO_W-1], 4'b0000} +: 16];

  always_comb begin
    unique case (size_e'(size_i))
      SZ_BYTE: result_o = {{(WORD_W-8){signed_i & byte_sel[7]}}, byte_sel};
      SZ_HALF: result_o = {{(WORD_W-16){signed_i & half_sel[15]}}, half_sel};
      default: result_o = rdata_i;
    endcase
  end
endmodule

// File: rtl/mem_lane_unit.sv
module mem_lane_unit
  import lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DISP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              write_i,
  input  logic [1:0]        size_i,
  input  logic              signed_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LANES-1:0]  mem_be_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              fault_o,
  output logic [ADDR_W-1:0] fault_addr_o,
  output logic              ld_valid_o,
  output logic [WORD_W-1:0] ld_data_o
);
  lsu_state_e        st_q;
  logic [ADDR_W-1:0] addr_q, fault_addr_q, ea;
  logic              we_q, sgn_q, fault_q, ld_valid_q, misalign, accept;
  logic [1:0]        size_q;
  logic [LANES-1:0]  be_q, be_d;
  logic [WORD_W-1:0] wdata_q, wdata_d, ld_data_q, ld_res;

  lsu_agen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_agen (
    .base_i    (base_i),
    .disp_i    (disp_i),
    .size_i    (size_i),
    .ea_o      (ea),
    .misalign_o(misalign)
  );

  lsu_store_lane u_store (
    .size_i(size_i),
    .lo_i  (ea[LO_W-1:0]),
    .src_i (wdata_i),
    .be_o  (be_d),
    .data_o(wdata_d)
  );

  lsu_load_ext u_load (
    .size_i  (size_q),
    .signed_i(sgn_q),
    .lo_i    (addr_q[LO_W-1:0]),
    .rdata_i (mem_rdata_i),
    .result_o(ld_res)
  );

  assign accept = req_valid_i && (st_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      addr_q       <= '0;
      we_q         <= 1'b0;
      be_q         <= '0;
      wdata_q      <= '0;
      size_q       <= 2'b00;
      sgn_q        <= 1'b0;
      fault_q      <= 1'b0;
      fault_addr_q <= '0;
      ld_valid_q   <= 1'b0;
      ld_data_q    <= '0;
    end else begin
      fault_q    <= 1'b0;
      ld_valid_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          if (misalign) begin
            fault_q      <= 1'b1;
            fault_addr_q <= ea;
          end else begin
            st_q    <= ST_REQ;
            addr_q  <= ea;
            we_q    <= write_i;
            be_q    <= be_d;
            wdata_q <= wdata_d;
            size_q  <= size_i;
            sgn_q   <= signed_i;
          end
        end
        ST_REQ: if (mem_ready_i) st_q <= we_q ? ST_IDLE : ST_RESP;
        ST_RESP: if (mem_rvalid_i) begin
          ld_valid_q <= 1'b1;
          ld_data_q  <= ld_res;
          st_q       <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (st_q == ST_IDLE);
  assign mem_valid_o  = (st_q == ST_REQ);
  assign mem_we_o     = we_q;
  assign mem_addr_o   = addr_q;
  assign mem_be_o     = be_q;
  assign mem_wdata_o  = wdata_q;
  assign fault_o      = fault_q;
  assign fault_addr_o = fault_addr_q;
  assign ld_valid_o   = ld_valid_q;
  assign ld_data_o    = ld_data_q;
endmodule

// File: rtl/mem_lane_unit_chk.sv
module mem_lane_unit_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              mem_valid_o,
  input logic              mem_ready_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [3:0]        mem_be_o,
  input logic              mem_rvalid_i,
  input logic              fault_o,
  input logic              ld_valid_o
);
  p_fault_no_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !mem_valid_o && !ld_valid_o);

  p_hold_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_be_o));

  p_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> !req_ready_o);

  p_strobe_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2 ||
                     $countones(mem_be_o) == 4));

  p_word_aligned_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && (mem_be_o == 4'hF) |-> (mem_addr_o[1:0] == 2'b00));

  p_ld_after_rvalid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_o |-> $past(mem_rvalid_i));
endmodule

bind mem_lane_unit mem_lane_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .mem_valid_o (mem_valid_o),
  .mem_ready_i (mem_ready_i),
  .mem_addr_o  (mem_addr_o),
  .mem_be_o    (mem_be_o),
  .mem_rvalid_i(mem_rvalid_i),
  .fault_o     (fault_o),
  .ld_valid_o  (ld_valid_o)
);

// File: tb/sim_mem_lane_unit.sv
`timescale 1ns/1ps
module sim_mem_lane_unit;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_valid_i = 0, write_i = 0, signed_i = 0;
  logic [1:0]  size_i = 0;
  logic [31:0] base_i = 0, wdata_i = 0, mem_rdata_i = 0;
  logic [15:0] disp_i = 0;
  logic        mem_ready_i = 0, mem_rvalid_i = 0;
  logic        req_ready_o, mem_valid_o, mem_we_o, fault_o, ld_valid_o;
  logic [31:0] mem_addr_o, mem_wdata_o, fault_addr_o, ld_data_o;
  logic [3:0]  mem_be_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  mem_lane_unit u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit exp_mis(input logic [1:0] sz, input logic [31:0] a);
    if (sz == 2'b00) return 1'b0;
    if (sz == 2'b01) return a[0];
    return a[1:0] != 2'b00;
  endfunction

  function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] lo);
    if (sz == 2'b00) return 4'b0001 << lo;
    if (sz == 2'b01) return 4'b0011 << lo;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] exp_wd(input logic [1:0] sz, input logic [31:0] s);
    if (sz == 2'b00) return {4{s[7:0]}};
    if (sz == 2'b01) return {2{s[15:0]}};
    return s;
  endfunction

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [31:0] exp_ld(input logic [1:0] sz, input bit sg,
                                         input logic [1:0] lo, input logic [31:0] rd);
    logic [7:0] b;
    logic [15:0] h;
    b = rd >> (8 * lo);
    h = lo[1] ? rd[31:16] : rd[15:0];
    if (sz == 2'b00) return sg ? {{24{b[7]}}, b} : {24'h0, b};
    if (sz == 2'b01) return sg ? {{16{h[15]}}, h} : {16'h0, h};
    return rd;
  endfunction

  function automatic string ld_tag(input logic [1:0] sz, input bit sg);
    if (sz == 2'b00) return sg ? "R3 byte sext" : "R2 byte zext";
    if (sz == 2'b01) return "R4 half ext";
    return "R5 word";
  endfunction

  task automatic run(input bit wr, input logic [1:0] sz, input bit sg,
                     input logic [31:0] base, input logic [15:0] disp,
                     input logic [31:0] src, input logic [31:0] rd,
                     input int rdly, input int vdly);
    logic [31:0] ea;
    logic [3:0]  be;
    ea = base + {{16{disp[15]}}, disp};
    be = exp_be(sz, ea[1:0]);
    @(negedge clk_i);
    chk("R9 ready when idle", 32'(req_ready_o), 32'd1);
    req_valid_i = 1; write_i = wr; size_i = sz; signed_i = sg;
    base_i = base; disp_i = disp; wdata_i = src;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 0;
    wdata_i = $urandom;
    if (exp_mis(sz, ea)) begin
      chk("R7 fault pulse", 32'(fault_o), 32'd1);
      chk("R7 fault addr", fault_addr_o, ea);
      chk("R7 no mem req", 32'(mem_valid_o), 32'd0);
      @(negedge clk_i);
      chk("R7 fault one cycle", 32'(fault_o), 32'd0);
      chk("R7 no mem req later", 32'(mem_valid_o), 32'd0);
      return;
    end
    chk("R6 aligned no fault", 32'(fault_o), 32'd0);
    chk("R9 mem valid", 32'(mem_valid_o), 32'd1);
    chk("R9 busy", 32'(req_ready_o), 32'd0);
    chk("R1 address", mem_addr_o, ea);
    chk("R11 write enable", 32'(mem_we_o), 32'(wr));
    chk("R8 strobes", 32'(mem_be_o), 32'(be));
    if (wr) chk("R8 lane data", mem_wdata_o & lane_mask(be), exp_wd(sz, src) & lane_mask(be));
    for (int i = 0; i < rdly; i++) begin
      @(negedge clk_i);
      chk("R9 request held", 32'(mem_valid_o), 32'd1);
      chk("R9 address held", mem_addr_o, ea);
    end
    mem_ready_i = 1;
    @(posedge clk_i);
    @(negedge clk_i);
    mem_ready_i = 0;
    chk("R9 request released", 32'(mem_valid_o), 32'd0);
    if (wr) begin
      chk("R11 store no load result", 32'(ld_valid_o), 32'd0);
      chk("R11 store done ready", 32'(req_ready_o), 32'd1);
      return;
    end
    for (int i = 0; i < vdly; i++) begin
      chk("R10 no early result", 32'(ld_valid_o), 32'd0);
      @(negedge clk_i);
    end
    mem_rvalid_i = 1; mem_rdata_i = rd;
    @(posedge clk_i);
    @(negedge clk_i);
    mem_rvalid_i = 0; mem_rdata_i = $urandom;
    chk("R10 result valid", 32'(ld_valid_o), 32'd1);
    chk(ld_tag(sz, sg), ld_data_o, exp_ld(sz, sg, ea[1:0], rd));
    @(negedge clk_i);
    chk("R10 result one cycle", 32'(ld_valid_o), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd1207));
    repeat (3) @(negedge clk_i);
    chk("reset mem_valid", 32'(mem_valid_o), 32'd0);
    chk("reset fault", 32'(fault_o), 32'd0);
    chk("reset ld_valid", 32'(ld_valid_o), 32'd0);
    chk("reset ready", 32'(req_ready_o), 32'd1);
    rst_ni = 1;

    // directed corners
    run(0, 2'b00, 0, 32'h1000, 16'h0003, 0, 32'h80A1B2C3, 0, 0); // lane 3 zext
    run(0, 2'b00, 1, 32'h1000, 16'h0003, 0, 32'h80A1B2C3, 1, 2); // lane 3 sext
    run(0, 2'b00, 1, 32'h1001, 16'h0000, 0, 32'h0000F700, 0, 0); // lane 1 sext
    run(0, 2'b01, 1, 32'h2000, 16'h0002, 0, 32'h8001_7FFF, 0, 1); // upper half sext
    run(0, 2'b01, 0, 32'h2000, 16'h0002, 0, 32'h8001_7FFF, 2, 0);
    run(0, 2'b01, 1, 32'h2000, 16'h0000, 0, 32'h8001_7FFF, 0, 0);
    run(0, 2'b10, 1, 32'h3000, 16'hFFFC, 0, 32'hFEDC_BA98, 0, 0); // negative disp
    run(0, 2'b11, 1, 32'h3000, 16'h0008, 0, 32'h8000_0001, 0, 0); // spare size code
    run(0, 2'b01, 0, 32'h2000, 16'h0001, 0, 0, 0, 0);            // half misaligned
    run(1, 2'b10, 0, 32'h2000, 16'h0002, 32'h1234_5678, 0, 0, 0); // word misaligned
    run(1, 2'b00, 1, 32'h0000_0000, 16'h8000, 32'hAABB_CCDD, 0, 0, 0); // wrap below 0
    run(1, 2'b01, 0, 32'hFFFF_FFFE, 16'h7FFF, 32'h1122_3344, 0, 3, 0); // wrap above
    run(1, 2'b00, 0, 32'h4000, 16'h0002, 32'h0000_00EE, 0, 0, 0);
    run(1, 2'b10, 1, 32'h4000, 16'h0004, 32'hCAFE_F00D, 0, 1, 0);

    for (int n = 0; n < 400; n++) begin
      logic [31:0] b;
      logic [15:0] d;
      b = $urandom;
      d = 16'($urandom);
      run(1'($urandom), 2'($urandom), 1'($urandom), b, d, $urandom, $urandom,
          int'($urandom % 3), int'($urandom % 3));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule